// File: doc/BRIEF.md
# Table-Based Hyperbolic Tangent Activation Unit

This block produces a fixed-point approximation of tanh(x) for use as a neuron activation function. It accepts one signed input sample per clock, qualified by a valid strobe. It returns the approximated value two clock edges later, with a matching valid strobe. The input carries one sign bit, two integer bits and a parameterised number of fractional bits, so it covers [-4, +4). The output carries one sign bit, one integer bit and a parameterised number of fractional bits, so both -1 and +1 can be represented exactly.

The input is turned into a table index by an affine map. Its gain and offset are powers of two, so the map needs only a shift and an add, with no multiplier. The table holds 2^ADDR_W samples of tanh, one at the centre of each equal-width bin across [-4, +4). The samples are computed from the parameters when the design is elaborated. Near the ends of the range the bin values round to exactly -1 and +1, and this gives the saturated behaviour.

Top module: `tanh_lut_approx`

## Requirements
- R1: The table index is round-half-up(x·2^(ADDR_W-3) + 2^(ADDR_W-1) - 0.5), clamped to [0, 2^ADDR_W - 1], where x is the input code divided by 2^FRAC_IN. At defaults x = -4.0 and x = -3.75 both give index 0, and x = +3.75 and above give index 15.
- R2: Entry k of the table is round-to-nearest(tanh(-4 + (k + 0.5)·8/2^ADDR_W) · 2^FRAC_OUT), clamped to ±2^FRAC_OUT. The output is that value as a two's-complement code with FRAC_OUT fractional bits.
- R3: At default parameters the lowest bin returns the code for -1 (-128) and the highest bin returns the code for +1 (+128).
- R4: A negative input never yields a positive output, and a non-negative input never yields a negative output.
- R5: A sample applied before rising edge t appears on `out_y` after edge t+1. A new sample can be accepted on every edge.
- R6: `out_valid` equals `in_valid` delayed by exactly two rising edges.
- R7: When no valid sample reaches the output stage, `out_y` holds its last value, whatever `in_x` carries.
- R8: A low `rst_n` at a rising edge clears `out_valid` and `out_y` to zero and discards any sample in flight.
- R9: An index value that lands exactly halfway between two integers rounds up. At defaults x = +1.0 selects index 10 and yields 109.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_x` on this edge |
| in_x | input | FRAC_IN+3 | Signed input, FRAC_IN fractional bits |
| out_valid | output | 1 | Qualifies `out_y` |
| out_y | output | FRAC_OUT+2 | Signed result, FRAC_OUT fractional bits |

## Verification
Every result is due two rising edges after its input is sampled. The bench drives on falling edges and reads the output on the second falling edge after each drive. One edge after a drive it confirms that the valid strobe is still low. In the streaming sweep, each input code is compared with the output read two drives later, so the full-rate path is checked against the same two-edge delay. The hold, reset-flush and idle checks read the outputs on falling edges placed the same way.

// File: rtl/tanh_lut_pkg.sv
// Package: shared helpers for the tanh table approximator.
// Assumes: called only with constant arguments during elaboration.
package tanh_lut_pkg;

    // Rounded, clamped table code for bin k.
    function automatic int tanh_bin_code(input int k, input int addr_w, input int frac_out);
        real centre;
        real e2;
        real t;
        real scaled;
        int  code;
        int  one;
        centre = -4.0 + (real'(k) + 0.5) * 8.0 / real'(1 << addr_w);
        e2     = $exp(2.0 * centre);
        t      = (e2 - 1.0) / (e2 + 1.0);
        scaled = t * real'(1 << frac_out);
        code   = $rtoi($floor(scaled + 0.5));
        one    = 1 << frac_out;
        if (code > one)  code = one;
        if (code < -one) code = -one;
        return code;
    endfunction

endpackage

// File: rtl/tanh_index_map.sv
// Module: maps a signed input code to a table index with shift and add.
// Assumes: ADDR_W >= 2, input has 2 integer bits and FRAC_IN fractional bits.
module tanh_index_map #(
    parameter int ADDR_W  = 4,
    parameter int FRAC_IN = 6,
    localparam int IN_W   = FRAC_IN + 3,
    localparam int SUM_W  = IN_W + ADDR_W + 1
) (
    input  logic [IN_W-1:0]   x,
    output logic [ADDR_W-1:0] idx
);
    localparam logic signed [SUM_W-1:0] BIAS    = SUM_W'(1) <<< (ADDR_W + FRAC_IN);
    localparam logic signed [SUM_W-1:0] TOP_IDX = SUM_W'((1 << ADDR_W) - 1);

    logic signed [SUM_W-1:0] widened;
    logic signed [SUM_W-1:0] biased;
    logic signed [SUM_W-1:0] shifted;

    // Scale by the gain, add offset plus rounding half, truncate, clamp.
    always_comb begin
        widened = {{(SUM_W-IN_W){x[IN_W-1]}}, x};
        biased  = (widened <<< (ADDR_W - 2)) + BIAS;
        shifted = biased >>> (FRAC_IN + 1);
        if (biased < 0)
            idx = '0;
        else if (shifted > TOP_IDX)
            idx = TOP_IDX[ADDR_W-1:0];
        else
            idx = shifted[ADDR_W-1:0];
    end
endmodule

// File: rtl/tanh_sample_rom.sv
// Module: constant table of tanh samples at bin centres, read combinationally.
// Assumes: contents fixed at elaboration; OUT_W <= 32.
module tanh_sample_rom #(
    parameter int ADDR_W   = 4,
    parameter int FRAC_OUT = 7,
    localparam int OUT_W   = FRAC_OUT + 2,
    localparam int DEPTH   = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] idx,
    output logic [OUT_W-1:0]  sample
);
    logic [OUT_W-1:0] table_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int CODE = tanh_lut_pkg::tanh_bin_code(k, ADDR_W, FRAC_OUT);
        assign table_q[k] = CODE[OUT_W-1:0];
    end

    // Select the addressed entry.
    assign sample = table_q[idx];
endmodule

// File: rtl/tanh_lut_approx.sv
// Module: two-stage pipelined tanh approximator (input register, lookup, output register).
// Assumes: synchronous active-low reset; ADDR_W >= 2.
module tanh_lut_approx #(
    parameter int ADDR_W   = 4,
    parameter int FRAC_IN  = 6,
    parameter int FRAC_OUT = 7,
    localparam int IN_W    = FRAC_IN + 3,
    localparam int OUT_W   = FRAC_OUT + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_x,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_y
);
    localparam int ONE = 1 << FRAC_OUT;

    logic              stg_valid;
    logic [IN_W-1:0]   stg_x;
    logic [ADDR_W-1:0] rom_idx;
    logic [OUT_W-1:0]  rom_sample;
    logic [1:0]        warm;

    // Input stage: capture the sample when it is qualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_valid <= 1'b0;
            stg_x     <= '0;
        end else begin
            stg_valid <= in_valid;
            if (in_valid) stg_x <= in_x;
        end
    end

    tanh_index_map #(.ADDR_W(ADDR_W), .FRAC_IN(FRAC_IN)) i_map (
        .x   (stg_x),
        .idx (rom_idx)
    );

    tanh_sample_rom #(.ADDR_W(ADDR_W), .FRAC_OUT(FRAC_OUT)) i_rom (
        .idx    (rom_idx),
        .sample (rom_sample)
    );

    // Output stage: register the looked-up sample, hold it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= '0;
        end else begin
            out_valid <= stg_valid;
            if (stg_valid) out_y <= rom_sample;
        end
    end

    // Edges since reset, saturating at 2; gates the history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n)           warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !$past(in_valid, 2)) |-> $stable(out_y));

    a_r4_sign_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(in_valid, 2)) |->
        ($past(in_x[IN_W-1], 2) ? ($signed(out_y) <= 0) : ($signed(out_y) >= 0)));

    a_r2_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(out_y) <= ONE) && ($signed(out_y) >= -ONE));
endmodule

// File: tb/test_tanh_lut_approx.sv
module test_tanh_lut_approx;
    localparam int ADDR_W   = 4;
    localparam int FRAC_IN  = 6;
    localparam int FRAC_OUT = 7;
    localparam int IN_W     = FRAC_IN + 3;
    localparam int OUT_W    = FRAC_OUT + 2;
    localparam int NVEC     = 11;

    // Directed vectors: input code and expected output code at defaults.
    localparam int VEC_X [NVEC] = '{-256, -240, -65, -64, -1, 0, 63, 64, 95, 96, 255};
    localparam int VEC_Y [NVEC] = '{-128, -128, -109, -81, -31, 31, 81, 109, 109, 120, 128};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [IN_W-1:0]  in_x;
    logic             out_valid;
    logic [OUT_W-1:0] out_y;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    tanh_lut_approx #(.ADDR_W(ADDR_W), .FRAC_IN(FRAC_IN), .FRAC_OUT(FRAC_OUT)) i_tanh_lut_approx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference from the requirements: real-valued index and bin centre.
    function automatic int ref_y(input int code);
        real x, a, c, e2, t;
        int  idx, r, one;
        x   = real'(code) / real'(1 << FRAC_IN);
        a   = x * (real'(1 << ADDR_W) / 8.0) + real'(1 << (ADDR_W - 1)) - 0.5;
        idx = $rtoi($floor(a + 0.5));
        if (idx < 0) idx = 0;
        if (idx > (1 << ADDR_W) - 1) idx = (1 << ADDR_W) - 1;
        c   = -4.0 + (real'(idx) + 0.5) * 8.0 / real'(1 << ADDR_W);
        e2  = $exp(2.0 * c);
        t   = (e2 - 1.0) / (e2 + 1.0);
        r   = $rtoi($floor(t * real'(1 << FRAC_OUT) + 0.5));
        one = 1 << FRAC_OUT;
        if (r > one) r = one;
        if (r < -one) r = -one;
        return r;
    endfunction

    function automatic int y_now();
        return int'($signed(out_y));
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int last;
        int prev1;
        int prev2;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_x     = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset valid", int'(out_valid), 0);
        check("R8 reset data", y_now(), 0);
        rst_n = 1'b1;

        // Vector table: R1 index, R2 values, R3 ends, R9 tie at x=+1.0
        last = 0;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_x     = IN_W'(VEC_X[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check("R5 not early", int'(out_valid), 0);
            @(negedge clk);
            check("R6 valid", int'(out_valid), 1);
            check((i == 7) ? "R9 tie" : ((i == 0 || i == 10) ? "R3 saturate" : "R2 value"),
                  y_now(), VEC_Y[i]);
            last = VEC_Y[i];
        end

        // R7: idle input changes do not disturb the output
        in_x = IN_W'(-200);
        repeat (3) @(negedge clk);
        check("R7 hold data", y_now(), last);
        check("R7 idle valid", int'(out_valid), 0);

        // R1 R4 R5: stream every code back to back
        prev1 = 0;
        prev2 = 0;
        for (int code = -(1 << (IN_W - 1)); code < (1 << (IN_W - 1)) + 2; code++) begin
            @(negedge clk);
            if (code >= -(1 << (IN_W - 1)) + 2) begin
                check("R5 stream valid", int'(out_valid), 1);
                check("R1 sweep", y_now(), ref_y(prev2));
                check("R4 sign", int'(prev2 < 0 ? y_now() > 0 : y_now() < 0), 0);
            end
            prev2 = prev1;
            prev1 = code;
            in_valid = (code < (1 << (IN_W - 1)));
            in_x     = IN_W'(code);
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 drain", int'(out_valid), 0);

        // R8: reset flushes a sample in flight
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = IN_W'(255);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R8 flush valid", int'(out_valid), 0);
        check("R8 flush data", y_now(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 no late valid", int'(out_valid), 0);
        check("R8 no late data", y_now(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule